// File: doc/BRIEF.md
# Pin Output Latch with Atomic Set, Clear and Toggle

This block is the output stage of a four-pin general-purpose port. It holds one output data latch bit per pin and one direction bit per pin. A simple register port updates both. Besides a plain data register, the port offers three write-only alias registers: set, clear and toggle. A write to one of these changes only the latch bits written as one. Software can therefore update a single pin without a read-modify-write sequence, and without a race against other code that drives neighbouring pins.

The latch keeps updating whether or not a pin is configured as an output. The direction bit only decides whether the pin is driven. Each pin is presented as a data bit plus an output-enable bit. The pad itself, input sampling, pin multiplexing and interrupts sit outside this block.

Top module: `gpio_out_port`

## Requirements
- R1: Word addresses on `addr_i` are: 0 data, 1 direction, 2 set, 3 clear, 4 toggle. Pin k uses data bit 4+k, so bits 7..4 hold the pin field. All other data bits read as zero, and writes to them are ignored.
- R2: A zero bit written to the set, clear or toggle register leaves that pin's latch unchanged.
- R3: A read of the set, clear or toggle register returns zero. A read of an unmapped address also returns zero.
- R4: A one bit written to the set register drives that pin's latch high.
- R5: A one bit written to the clear register drives that pin's latch low.
- R6: A one bit written to the toggle register inverts that pin's latch.
- R7: `pin_oe_o[k]` equals direction bit k, where 1 means output. `pin_out_o[k]` follows latch k while the pin is an output and is 0 otherwise. The latch still updates while the pin is not an output.
- R8: A write to the data register loads the latch from bits 7..4. Reads of the data and direction registers return the latch and direction values in bits 7..4.
- R9: A latch or direction write takes effect on the clock edge that accepts it. `rd_data_o` presents the read value one cycle after `rd_en_i`, and is zero after a cycle with no read. A read issued in the same cycle as a write returns the state from before that write.
- R10: An active-low asynchronous reset clears the latch and the direction bits, so no pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| pin_out_o | output | 4 | Pin output level |
| pin_oe_o | output | 4 | Pin output enable |

## Verification
A corrupted latch bit on a pin set as an output appears on `pin_out_o` right after the edge of the faulty write. On a pin that is not an output, the same fault shows only through a data-register read, one cycle after that read is issued. The bench therefore reads back the latch and the direction bits after every table step, as well as checking the pins. A wrong direction bit shows at once on `pin_oe_o`. A decode slip that makes an alias register read nonzero shows on the read data one cycle after the read.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;
  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_SET  = 3'd2,
    REG_CLR  = 3'd3,
    REG_TGL  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic wr_data;
    logic wr_dir;
    logic wr_set;
    logic wr_clr;
    logic wr_tgl;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_out_regif.sv
module gpio_out_regif
  import gpio_out_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int PIN_LSB  = 4,
  parameter int NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] dir_i,
  output wr_strobe_t          strobe_o,
  output logic [NUM_PINS-1:0] field_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam logic [DATA_W-1:0] FIELD_MASK = {{(DATA_W-NUM_PINS){1'b0}}, {NUM_PINS{1'b1}}} << PIN_LSB;

  logic sel_data, sel_dir, sel_set, sel_clr, sel_tgl;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rd_q;
  logic unused_wdata;

  assign sel_data = (addr_i == ADDR_W'(REG_DATA));
  assign sel_dir  = (addr_i == ADDR_W'(REG_DIR));
  assign sel_set  = (addr_i == ADDR_W'(REG_SET));
  assign sel_clr  = (addr_i == ADDR_W'(REG_CLR));
  assign sel_tgl  = (addr_i == ADDR_W'(REG_TGL));

  assign strobe_o.wr_data = wr_en_i & sel_data;
  assign strobe_o.wr_dir  = wr_en_i & sel_dir;
  assign strobe_o.wr_set  = wr_en_i & sel_set;
  assign strobe_o.wr_clr  = wr_en_i & sel_clr;
  assign strobe_o.wr_tgl  = wr_en_i & sel_tgl;

  // reserved bits never leave this module
  assign field_o      = wr_data_i[PIN_LSB +: NUM_PINS];
  assign unused_wdata = ^(wr_data_i & ~FIELD_MASK);

  always_comb begin
    rd_val = '0;
    if (sel_data) rd_val[PIN_LSB +: NUM_PINS] = latch_i;
    else if (sel_dir) rd_val[PIN_LSB +: NUM_PINS] = dir_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_en_i ? rd_val : '0;
  end

  assign rd_data_o = rd_q;

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~FIELD_MASK) == '0);

  p_alias_rd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (sel_set || sel_clr || sel_tgl)) |=> (rd_data_o == '0));

  p_idle_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rd_data_o == '0));
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_out_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wr_strobe_t          strobe_i,
  input  logic [NUM_PINS-1:0] field_i,
  output logic [NUM_PINS-1:0] latch_o,
  output logic [NUM_PINS-1:0] dir_o
);
  logic [NUM_PINS-1:0] latch_q, dir_q;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             latch_q[k] <= 1'b0;
      else if (strobe_i.wr_data)               latch_q[k] <= field_i[k];
      else if (strobe_i.wr_set && field_i[k])  latch_q[k] <= 1'b1;
      else if (strobe_i.wr_clr && field_i[k])  latch_q[k] <= 1'b0;
      else if (strobe_i.wr_tgl && field_i[k])  latch_q[k] <= ~latch_q[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              dir_q[k] <= 1'b0;
      else if (strobe_i.wr_dir) dir_q[k] <= field_i[k];
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i.wr_set |=> ((latch_q & $past(field_i)) == $past(field_i)));

  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i.wr_clr |=> ((latch_q & $past(field_i)) == '0));

  p_tgl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i.wr_tgl |=> ((latch_q ^ $past(latch_q)) == $past(field_i)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strobe_i.wr_set || strobe_i.wr_clr || strobe_i.wr_tgl) && field_i == '0) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_out_drive.sv
module gpio_out_drive #(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] dir_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pad
    assign pin_oe_o[k]  = dir_i[k];
    assign pin_out_o[k] = dir_i[k] & latch_i[k];
  end
endmodule

// File: rtl/gpio_out_port.sv
module gpio_out_port
  import gpio_out_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int PIN_LSB  = 4,
  parameter int NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  wr_strobe_t          strobe;
  logic [NUM_PINS-1:0] field, latch, dir;

  gpio_out_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIN_LSB(PIN_LSB), .NUM_PINS(NUM_PINS)
  ) u_regif (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i,
    .latch_i(latch), .dir_i(dir), .strobe_o(strobe), .field_o(field), .rd_data_o
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk_i, .rst_ni, .strobe_i(strobe), .field_i(field), .latch_o(latch), .dir_o(dir)
  );

  gpio_out_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .latch_i(latch), .dir_i(dir), .pin_out_o, .pin_oe_o
  );

  p_oe_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(REG_DIR)) |=> $stable(pin_oe_o));

  p_undriven_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);
endmodule

// File: tb/gpio_out_port_tb_top.sv
module gpio_out_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [3:0]  pin_out_o, pin_oe_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_out_port dut_i (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i,
    .rd_data_o, .pin_out_o, .pin_oe_o
  );

  // {op, wdata, expected latch, expected dir}; op is the word address
  localparam logic [42:0] VEC [13] = '{
    {3'd2, 32'h000000A0, 4'hA, 4'h0},
    {3'd1, 32'h000000F0, 4'hA, 4'hF},
    {3'd3, 32'h00000020, 4'h8, 4'hF},
    {3'd4, 32'h000000F0, 4'h7, 4'hF},
    {3'd2, 32'hFFFFFF0F, 4'h7, 4'hF},
    {3'd3, 32'h00000000, 4'h7, 4'hF},
    {3'd1, 32'h00000030, 4'h7, 4'h3},
    {3'd4, 32'h00000090, 4'hE, 4'h3},
    {3'd0, 32'hFFFFFF5F, 4'h5, 4'h3},
    {3'd2, 32'h00000030, 4'h7, 4'h3},
    {3'd3, 32'h000000C0, 4'h3, 4'h3},
    {3'd1, 32'h00000000, 4'h3, 4'h0},
    {3'd4, 32'h00000010, 4'h2, 4'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10 oe", {28'd0, pin_oe_o}, 32'd0);
    chk("R10 out", {28'd0, pin_out_o}, 32'd0);
    rst_ni = 1'b1;
    bus_read(4'd0, rd); chk("R10 data", rd, 32'd0);
    bus_read(4'd1, rd); chk("R10 dir", rd, 32'd0);

    for (int i = 0; i < 13; i++) begin
      logic [2:0] op; logic [31:0] wd; logic [3:0] el, ed;
      {op, wd, el, ed} = VEC[i];
      bus_write({1'b0, op}, wd);
      // R9: pins reflect the write right after its edge
      chk("R7 R9 oe", {28'd0, pin_oe_o}, {28'd0, ed});
      chk("R7 R9 out", {28'd0, pin_out_o}, {28'd0, el & ed});
      bus_read(4'd0, rd); chk("R2 R4 R5 R6 R8 data", rd, {24'd0, el, 4'd0});
      bus_read(4'd1, rd); chk("R1 R8 dir", rd, {24'd0, ed, 4'd0});
    end

    // R3: alias and unmapped reads are zero while latch is nonzero
    bus_write(4'd0, 32'h000000B0);
    bus_read(4'd2, rd); chk("R3 set read", rd, 32'd0);
    bus_read(4'd3, rd); chk("R3 clr read", rd, 32'd0);
    bus_read(4'd4, rd); chk("R3 tgl read", rd, 32'd0);
    bus_read(4'd7, rd); chk("R3 unmapped read", rd, 32'd0);

    // R9: same-cycle read returns pre-write value; idle cycle reads zero
    @(negedge clk_i);
    addr_i = 4'd0; wr_data_i = 32'h00000060; wr_en_i = 1'b1; rd_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk("R9 read before write", rd_data_o, 32'h000000B0);
    @(negedge clk_i);
    chk("R9 idle read zero", rd_data_o, 32'd0);
    bus_read(4'd0, rd); chk("R9 R8 new value", rd, 32'h00000060);

    // R7: latch updates while undriven, then appears when enabled
    bus_write(4'd1, 32'h00000000);
    bus_write(4'd4, 32'h000000F0);
    chk("R7 undriven out", {28'd0, pin_out_o}, 32'd0);
    bus_write(4'd1, 32'h000000F0);
    chk("R7 enabled out", {28'd0, pin_out_o}, 32'h9);

    // R10: asynchronous reset clears between edges
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    chk("R10 async oe", {28'd0, pin_oe_o}, 32'd0);
    chk("R10 async out", {28'd0, pin_out_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(4'd0, rd); chk("R10 data after reset", rd, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule